// File: doc/BRIEF.md
# Hall Sensor Commutation Decoder

This block converts three single-ended Hall sensor levels into switch commands for a three-leg power bridge. For each leg it drives one of three states: supply (high-side switch on), ground (low-side switch on) or high impedance (both off). A single decode table handles both 60-degree and 120-degree sensor spacing, so no configuration input is needed. Motors with 240-degree or 300-degree spacing are driven by selecting the opposite direction.

The Hall inputs are asynchronous and pass through a two-flop synchroniser before decoding. A direction input mirrors the drive. An active-low brake input turns on all three high-side switches. An enable input, when low, turns every switch off and overrides brake. Whenever the commanded state of a leg changes, both switches of that leg stay off for a programmable number of cycles, which prevents cross conduction. A tacho output is released for a programmable number of cycles after each rising edge of sensor 1. It can feed a frequency-to-voltage speed loop.

Top module: `hall_commutator`

## Requirements
- R1: Hall code in bit order (sensor1, sensor2, sensor3), with `hall_i[0]` as sensor1, `hall_i[1]` as sensor2 and `hall_i[2]` as sensor3. With direction high, legs (1, 2, 3) are driven as follows: 100 gives supply, Z, ground; 110 gives Z, supply, ground; 010 gives ground, supply, Z; 011 gives ground, Z, supply; 001 gives Z, ground, supply; 101 gives supply, ground, Z. Supply means only `hs_on_o[leg]` is high, ground means only `ls_on_o[leg]` is high, and Z means both are low.
- R2: The two codes that occur only with 60-degree spacing decode as follows: 111 gives ground, supply, Z; 000 gives supply, ground, Z.
- R3: With `fwd_i` low, every leg that would be driven to supply is driven to ground and every leg that would be driven to ground is driven to supply. Z legs stay Z.
- R4: With `en_i` high and `brake_n_i` low, the target of all three legs is supply, whatever the Hall code and direction.
- R5: With `en_i` low, the target of all legs is Z. Enable takes priority over brake, and brake takes priority over the Hall decode.
- R6: A Hall value sampled at clock edge k sets the leg targets at edge k+2.
- R7: When a leg's target differs from its held command at an edge, both of that leg's switches are off for the next DEAD_CYC cycles and the new drive appears DEAD_CYC cycles after that edge. A further change during the gap restarts it. A high-side and low-side switch of one leg are never on in consecutive cycles without a gap.
- R8: A rising edge of sensor1 sampled at edge k makes `tacho_rel_o` high from edge k+2 for exactly TACHO_LEN cycles.
- R9: A new rising edge of sensor1 while `tacho_rel_o` is high reloads the pulse to TACHO_LEN cycles.
- R10: During and directly after reset, all switch outputs and `tacho_rel_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Raw Hall sensor levels, bit 0 = sensor1 |
| fwd_i | input | 1 | Direction: 1 forward, 0 reverse |
| brake_n_i | input | 1 | Active-low brake, all high-side switches on |
| en_i | input | 1 | Bridge enable, low turns all switches off |
| hs_on_o | output | 3 | High-side switch on, one bit per leg |
| ls_on_o | output | 3 | Low-side switch on, one bit per leg |
| tacho_rel_o | output | 1 | High while the tacho pulse is active (open-drain device released) |

## Verification
A Hall change sampled at edge k reaches the leg commands at edge k+2. The affected switch outputs go low after that edge and take their new value DEAD_CYC edges later. Enable, brake and direction act on the commands at the very next edge. The tacho output rises two edges after a sensor1 rise is sampled. The bench holds a behavioural model that keeps a queue of sampled Hall codes and per-leg gap counters and advances it on every rising edge. It compares all outputs on the following falling edge, so each expected value is taken in the cycle where the registered result is due.

// File: rtl/hall_commutator.sv
module hall_commutator #(
  parameter int DEAD_CYC  = 4,
  parameter int TACHO_LEN = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hall_i,
  input  logic       fwd_i,
  input  logic       brake_n_i,
  input  logic       en_i,
  output logic [2:0] hs_on_o,
  output logic [2:0] ls_on_o,
  output logic       tacho_rel_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam int TW = $clog2(TACHO_LEN + 1);
  localparam logic [1:0] LEG_Z   = 2'b00;
  localparam logic [1:0] LEG_SUP = 2'b01;
  localparam logic [1:0] LEG_GND = 2'b10;

  logic [2:0]      s1, s2;
  logic            h1_d;
  logic [TW-1:0]   tcnt;
  logic [2:0][1:0] fwd_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      h1_d <= 1'b0;
    end else begin
      s1   <= hall_i;
      s2   <= s1;
      h1_d <= s2[0];
    end
  end

  always_comb begin
    case ({s2[0], s2[1], s2[2]})
      3'b100:         fwd_tgt = {LEG_GND, LEG_Z,   LEG_SUP};
      3'b110:         fwd_tgt = {LEG_GND, LEG_SUP, LEG_Z};
      3'b010, 3'b111: fwd_tgt = {LEG_Z,   LEG_SUP, LEG_GND};
      3'b011:         fwd_tgt = {LEG_SUP, LEG_Z,   LEG_GND};
      3'b001:         fwd_tgt = {LEG_SUP, LEG_GND, LEG_Z};
      default:        fwd_tgt = {LEG_Z,   LEG_GND, LEG_SUP};
    endcase
  end

  for (genvar g = 0; g < 3; g++) begin : g_leg
    logic [1:0]    want, cmd;
    logic [DW-1:0] dcnt;

    assign want = !en_i      ? LEG_Z :
                  !brake_n_i ? LEG_SUP :
                  fwd_i      ? fwd_tgt[g] : {fwd_tgt[g][0], fwd_tgt[g][1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd  <= LEG_Z;
        dcnt <= '0;
      end else if (want != cmd) begin
        cmd  <= want;
        dcnt <= DW'(DEAD_CYC);
      end else if (dcnt != '0) begin
        dcnt <= dcnt - 1'b1;
      end
    end

    assign hs_on_o[g] = (cmd == LEG_SUP) && (dcnt == '0);
    assign ls_on_o[g] = (cmd == LEG_GND) && (dcnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tcnt <= '0;
    else if (s2[0] && !h1_d)   tcnt <= TW'(TACHO_LEN);
    else if (tcnt != '0)       tcnt <= tcnt - 1'b1;
  end

  assign tacho_rel_o = (tcnt != '0);

  // R5
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (hs_on_o == 3'b000 && ls_on_o == 3'b000));

  // R4
  brake_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !brake_n_i) |=> (ls_on_o == 3'b000));

  // R7
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(ls_on_o) & hs_on_o) | ($past(hs_on_o) & ls_on_o)) == 3'b000));

  // R8
  tacho_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tacho_rel_o) |-> $past(hall_i[0], 3));

endmodule

// File: tb/hall_commutator_tb.sv
module hall_commutator_tb_top;
  localparam int DEAD = 4;
  localparam int TLEN = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic       fwd = 1'b1, brake_n = 1'b1, en = 1'b0;
  logic [2:0] hs, ls;
  logic       tacho;

  int    compared = 0, mismatched = 0;
  string phase = "R10";
  bit    done = 1'b0;

  hall_commutator #(.DEAD_CYC(DEAD), .TACHO_LEN(TLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .hall_i(hall), .fwd_i(fwd),
    .brake_n_i(brake_n), .en_i(en), .hs_on_o(hs), .ls_on_o(ls),
    .tacho_rel_o(tacho));

  always #2 clk = ~clk;

  // leg drive: 0 = Z, 1 = supply, 2 = ground; code given as {sensor1,sensor2,sensor3}
  function automatic int fwd_leg(input logic [2:0] c, input int leg);
    int t[3];
    case (c)
      3'b100:         t = '{1, 0, 2};
      3'b110:         t = '{0, 1, 2};
      3'b010, 3'b111: t = '{2, 1, 0};
      3'b011:         t = '{2, 0, 1};
      3'b001:         t = '{0, 2, 1};
      default:        t = '{1, 2, 0};
    endcase
    return t[leg];
  endfunction

  logic [2:0] hist[$];
  int m_cmd[3], m_cnt[3], m_t;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {3'b000, 3'b000, 3'b000, 3'b000};
      m_t = 0;
      for (int i = 0; i < 3; i++) begin m_cmd[i] = 0; m_cnt[i] = 0; end
    end else begin
      logic [2:0] h;
      hist.push_front(hall);
      while (hist.size() > 4) void'(hist.pop_back());
      h = hist[2];
      for (int i = 0; i < 3; i++) begin
        int w;
        if (!en) w = 0;
        else if (!brake_n) w = 1;
        else begin
          w = fwd_leg({h[0], h[1], h[2]}, i);
          if (!fwd && w != 0) w = 3 - w;
        end
        if (w != m_cmd[i]) begin m_cmd[i] = w; m_cnt[i] = DEAD; end
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end
      if (hist[2][0] && !hist[3][0]) m_t = TLEN;
      else if (m_t > 0) m_t--;
    end
  end

  task automatic compare_now();
    logic [2:0] ehs, els;
    logic et;
    for (int i = 0; i < 3; i++) begin
      ehs[i] = (m_cmd[i] == 1) && (m_cnt[i] == 0);
      els[i] = (m_cmd[i] == 2) && (m_cnt[i] == 0);
    end
    et = (m_t != 0);
    compared++;
    if (hs !== ehs || ls !== els || tacho !== et) begin
      mismatched++;
      $display("FAIL %s t=%0t actual hs=%b ls=%b tacho=%b expected hs=%b ls=%b tacho=%b",
               phase, $time, hs, ls, tacho, ehs, els, et);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) compare_now();

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_code(input logic [2:0] c);  // c = {sensor1,sensor2,sensor3}
    hall = {c[0], c[1], c[2]};
  endtask

  logic [2:0] seq120[6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};
  logic [2:0] seq60[6]  = '{3'b100, 3'b110, 3'b111, 3'b011, 3'b001, 3'b000};

  initial begin
    hold(5);
    // R10 reset state
    compared++;
    if (hs !== 3'b000 || ls !== 3'b000 || tacho !== 1'b0) begin
      mismatched++;
      $display("FAIL R10 actual hs=%b ls=%b tacho=%b expected 000 000 0", hs, ls, tacho);
    end
    rst_n = 1'b1;
    hold(3);
    en = 1'b1;
    hold(12);
    phase = "R1";
    foreach (seq120[i]) begin set_code(seq120[i]); hold(12); end
    phase = "R2";
    set_code(3'b111); hold(12);
    set_code(3'b000); hold(12);
    phase = "R6";
    foreach (seq60[i]) begin set_code(seq60[i]); hold(10); end
    phase = "R3";
    fwd = 1'b0;
    foreach (seq120[i]) begin set_code(seq120[i]); hold(12); end
    set_code(3'b111); hold(12);
    phase = "R4";
    fwd = 1'b1; set_code(3'b100); hold(10);
    brake_n = 1'b0; hold(12);
    brake_n = 1'b1; hold(12);
    phase = "R5";
    brake_n = 1'b0; en = 1'b0; hold(10);
    brake_n = 1'b1; hold(4);
    en = 1'b1; hold(12);
    phase = "R7";
    for (int k = 0; k < 10; k++) begin
      set_code(k % 2 ? 3'b110 : 3'b100); hold(2);
    end
    hold(12);
    phase = "R8";
    for (int k = 0; k < 3; k++) begin
      set_code(3'b000); hold(30);
      set_code(3'b100); hold(30);
    end
    phase = "R9";
    for (int k = 0; k < 6; k++) begin
      set_code(3'b000); hold(3);
      set_code(3'b100); hold(3);
    end
    hold(40);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule